// File: doc/BRIEF.md
# Cache Front-End Stall Controller

This block decides when a cache's CPU-facing request port must stop taking new work. Three independent reasons can stall the port: the miss-status queue is out of entries, the write-back buffer is out of entries, or a miss entry has no room for further targets. The two queue reasons come from occupancy counters kept here. Each counter is fed by allocate and mark-in-service pulses. The third reason is set and cleared directly by the surrounding logic. The port stays stalled while any reason is active.

Alongside the stall logic, the block gives each accepted allocation a block-aligned address and a sequence number. The sequence number is shared by both queues. The block also registers a memory-side bus request that carries a reason code. For each stall reason it keeps a saturating count of stall episodes and a saturating count of stalled cycles. When the port reopens after a request was turned away during the stall, it emits a single retry pulse.

Top module: `cache_block_ctrl`

## Requirements
- R1: After reset, cpu_accept_o is 1, cpu_retry_o, bus_req_o, blocked_o and every counter are 0, and the next accepted allocation gets sequence number 0.
- R2: blocked_o bit 0 is the miss queue full, bit 1 is the write buffer full and bit 2 is no free targets. One cycle after an event changes the mask, cpu_accept_o equals 1 exactly when the mask is zero.
- R3: When the mask goes from zero to nonzero, the episode counter of every cause set in the new mask increases by one. Adding a cause to a mask that is already nonzero leaves all episode counters unchanged.
- R4: When the mask goes from nonzero to zero, every cause cleared in that cycle has the number of cycles cpu_accept_o was low added to its stalled-cycle counter. No stalled-cycle counter changes at any other time.
- R5: If cpu_req_i was high in any cycle with cpu_accept_o low, then cpu_retry_o is high for exactly the one cycle in which cpu_accept_o returns to 1. Otherwise cpu_retry_o stays 0.
- R6: An accepted allocation's output address is its input address with the low log2(BLK_BYTES) bits cleared. Sequence numbers rise by one for each accepted allocation and wrap modulo 2^ORD_W. If both queues allocate in the same cycle, the miss queue takes n and the write buffer takes n+1.
- R7: An accepted allocation that leaves its queue holding DEPTH entries sets that queue's cause bit.
- R8: A mark-in-service pulse lowers the occupancy of a non-empty queue. It clears the queue's cause bit only when the queue was full before the mark and is not full after it.
- R9: An allocation into a full queue raises that queue's alloc_err_o bit (bit 0 miss queue, bit 1 write buffer) in the same cycle. It consumes no sequence number and changes no occupancy.
- R10: One cycle after a request, bus_req_o is high with bus_cause_o set to 0 for an accepted miss allocation with its request flag, else 1 for an accepted write-buffer allocation with its request flag, else 2 for a prefetch request. With no request, bus_req_o is 0 and bus_cause_o is 3.
- R11: A cause set and cleared in the same cycle ends up clear. If the mask was zero, no episode is counted and the port stays open.
- R12: Episode and stalled-cycle counters saturate at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mq_alloc_i | input | 1 | Allocate a miss-queue entry |
| mq_addr_i | input | ADDR_W | Miss allocation address |
| mq_bus_i | input | 1 | Miss allocation requests the memory bus |
| mq_mark_i | input | 1 | Miss entry marked in service |
| wb_alloc_i | input | 1 | Allocate a write-buffer entry |
| wb_addr_i | input | ADDR_W | Write-buffer allocation address |
| wb_bus_i | input | 1 | Write-buffer allocation requests the memory bus |
| wb_mark_i | input | 1 | Write-buffer entry marked in service |
| pf_bus_i | input | 1 | Prefetch requests the memory bus |
| tgt_set_i | input | 1 | Set the no-targets cause |
| tgt_clr_i | input | 1 | Clear the no-targets cause |
| cpu_req_i | input | 1 | CPU-side request valid |
| cpu_accept_o | output | 1 | CPU side may issue |
| cpu_retry_o | output | 1 | One-cycle retry indication |
| blocked_o | output | 3 | Cause mask |
| mq_blk_addr_o | output | ADDR_W | Aligned miss address |
| wb_blk_addr_o | output | ADDR_W | Aligned write-buffer address |
| mq_order_o | output | ORD_W | Sequence number of the miss allocation |
| wb_order_o | output | ORD_W | Sequence number of the write-buffer allocation |
| alloc_err_o | output | 2 | Allocation into a full queue |
| bus_req_o | output | 1 | Memory-side bus request |
| bus_cause_o | output | 2 | Bus request reason code |
| evt_cnt_o | output | 3*CNT_W | Episode counters, cause i at bits i*CNT_W |
| blk_cyc_o | output | 3*CNT_W | Stalled-cycle counters, cause i at bits i*CNT_W |

## Verification
The hardest situations to reach are the overlaps at the mask edges. These include a queue being marked while full in the same cycle that it receives a rejected allocation, and an episode that opens and closes on different causes while a request is refused only on the very cycle the port reopens. A long pseudo-random sweep drives every input at once with biased rates. Because the rates keep both small queues near their limits, these overlaps happen many times. Directed phases cover same-cycle set and clear from an open port and the saturation of both counter kinds.

// File: rtl/cblk_pkg.sv
package cblk_pkg;
  localparam int NCAUSE = 3;
  typedef enum logic [1:0] {CAUSE_MQ = 2'd0, CAUSE_WB = 2'd1, CAUSE_TGT = 2'd2} cause_e;
  typedef enum logic [1:0] {BUS_MQ = 2'd0, BUS_WB = 2'd1, BUS_PF = 2'd2, BUS_NONE = 2'd3} bus_cause_e;
endpackage

// File: rtl/cblk_occ.sv
module cblk_occ #(
  parameter int DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alloc_i,
  input  logic mark_i,
  output logic alloc_ok_o,
  output logic alloc_err_o,
  output logic set_full_o,
  output logic clr_full_o
);
  localparam int OW = $clog2(DEPTH + 1);
  localparam logic [OW-1:0] FULLV = OW'(DEPTH);

  logic [OW-1:0] occ_q, occ_d;
  logic full_now, dec;

  assign full_now    = (occ_q == FULLV);
  assign alloc_ok_o  = alloc_i & ~full_now;
  assign alloc_err_o = alloc_i & full_now;
  assign dec         = mark_i & (occ_q != '0);
  assign occ_d       = occ_q + OW'(alloc_ok_o) - OW'(dec);
  assign set_full_o  = alloc_ok_o & (occ_d == FULLV);
  // release only on a full -> not-full transition
  assign clr_full_o  = dec & full_now & (occ_d != FULLV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= occ_d;
  end
endmodule

// File: rtl/cblk_sat_acc.sv
module cblk_sat_acc #(
  parameter int W  = 8,
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [IW-1:0] inc_i,
  output logic [W-1:0]  cnt_o
);
  localparam int SW = ((IW > W) ? IW : W) + 1;
  localparam logic [SW-1:0] MAXV = {{(SW-W){1'b0}}, {W{1'b1}}};

  logic [W-1:0]  cnt_q;
  logic [SW-1:0] sum;

  assign sum   = SW'(cnt_q) + SW'(inc_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= (sum > MAXV) ? W'(MAXV) : W'(sum);
  end
endmodule

// File: rtl/cblk_mask.sv
module cblk_mask
  import cblk_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CYC_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NCAUSE-1:0]       set_i,
  input  logic [NCAUSE-1:0]       clr_i,
  input  logic                    req_valid_i,
  output logic [NCAUSE-1:0]       mask_o,
  output logic                    accept_o,
  output logic                    retry_o,
  output logic [NCAUSE*CNT_W-1:0] evt_cnt_o,
  output logic [NCAUSE*CNT_W-1:0] blk_cyc_o
);
  logic [NCAUSE-1:0] mask_q, mask_d;
  logic [CYC_W-1:0]  cyc_q, start_q, elapsed;
  logic going_busy, going_free, refused;
  logic pend_q, retry_q, accept_q;

  // clear wins over set for the same cause
  assign mask_d     = (mask_q | set_i) & ~clr_i;
  assign going_busy = (mask_q == '0) & (mask_d != '0);
  assign going_free = (mask_q != '0) & (mask_d == '0);
  assign refused    = req_valid_i & (mask_q != '0);
  assign elapsed    = cyc_q - start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      cyc_q    <= '0;
      start_q  <= '0;
      pend_q   <= 1'b0;
      retry_q  <= 1'b0;
      accept_q <= 1'b1;
    end else begin
      mask_q   <= mask_d;
      cyc_q    <= cyc_q + 1'b1;
      accept_q <= (mask_d == '0);
      retry_q  <= going_free & (pend_q | refused);
      if (going_busy) start_q <= cyc_q;
      if (going_free)   pend_q <= 1'b0;
      else if (refused) pend_q <= 1'b1;
    end
  end

  assign mask_o   = mask_q;
  assign accept_o = accept_q;
  assign retry_o  = retry_q;

  for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
    cblk_sat_acc #(.W(CNT_W), .IW(1)) u_evt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (going_busy & mask_d[i]),
      .inc_i (1'b1),
      .cnt_o (evt_cnt_o[i*CNT_W +: CNT_W])
    );
    cblk_sat_acc #(.W(CNT_W), .IW(CYC_W)) u_cyc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (going_free & clr_i[i] & mask_q[i]),
      .inc_i (elapsed),
      .cnt_o (blk_cyc_o[i*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/cache_block_ctrl.sv
module cache_block_ctrl
  import cblk_pkg::*;
#(
  parameter int MQ_DEPTH  = 4,
  parameter int WB_DEPTH  = 2,
  parameter int ADDR_W    = 16,
  parameter int BLK_BYTES = 16,
  parameter int ORD_W     = 8,
  parameter int CNT_W     = 8,
  parameter int CYC_W     = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mq_alloc_i,
  input  logic [ADDR_W-1:0]       mq_addr_i,
  input  logic                    mq_bus_i,
  input  logic                    mq_mark_i,
  input  logic                    wb_alloc_i,
  input  logic [ADDR_W-1:0]       wb_addr_i,
  input  logic                    wb_bus_i,
  input  logic                    wb_mark_i,
  input  logic                    pf_bus_i,
  input  logic                    tgt_set_i,
  input  logic                    tgt_clr_i,
  input  logic                    cpu_req_i,
  output logic                    cpu_accept_o,
  output logic                    cpu_retry_o,
  output logic [2:0]              blocked_o,
  output logic [ADDR_W-1:0]       mq_blk_addr_o,
  output logic [ADDR_W-1:0]       wb_blk_addr_o,
  output logic [ORD_W-1:0]        mq_order_o,
  output logic [ORD_W-1:0]        wb_order_o,
  output logic [1:0]              alloc_err_o,
  output logic                    bus_req_o,
  output logic [1:0]              bus_cause_o,
  output logic [3*CNT_W-1:0]      evt_cnt_o,
  output logic [3*CNT_W-1:0]      blk_cyc_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BLK_BYTES - 1);

  logic mq_ok, wb_ok;
  logic [NCAUSE-1:0] set_v, clr_v;
  logic [ORD_W-1:0] order_q;
  logic bus_req_q;
  bus_cause_e bus_cause_q, bus_cause_d;

  cblk_occ #(.DEPTH(MQ_DEPTH)) u_mq_occ (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_i    (mq_alloc_i),
    .mark_i     (mq_mark_i),
    .alloc_ok_o (mq_ok),
    .alloc_err_o(alloc_err_o[0]),
    .set_full_o (set_v[CAUSE_MQ]),
    .clr_full_o (clr_v[CAUSE_MQ])
  );

  cblk_occ #(.DEPTH(WB_DEPTH)) u_wb_occ (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_i    (wb_alloc_i),
    .mark_i     (wb_mark_i),
    .alloc_ok_o (wb_ok),
    .alloc_err_o(alloc_err_o[1]),
    .set_full_o (set_v[CAUSE_WB]),
    .clr_full_o (clr_v[CAUSE_WB])
  );

  assign set_v[CAUSE_TGT] = tgt_set_i;
  assign clr_v[CAUSE_TGT] = tgt_clr_i;

  cblk_mask #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_v),
    .clr_i      (clr_v),
    .req_valid_i(cpu_req_i),
    .mask_o     (blocked_o),
    .accept_o   (cpu_accept_o),
    .retry_o    (cpu_retry_o),
    .evt_cnt_o  (evt_cnt_o),
    .blk_cyc_o  (blk_cyc_o)
  );

  assign mq_blk_addr_o = mq_addr_i & ALIGN_MASK;
  assign wb_blk_addr_o = wb_addr_i & ALIGN_MASK;
  // miss queue takes the lower number when both allocate together
  assign mq_order_o    = order_q;
  assign wb_order_o    = order_q + ORD_W'(mq_ok);

  always_comb begin
    if (mq_ok & mq_bus_i)      bus_cause_d = BUS_MQ;
    else if (wb_ok & wb_bus_i) bus_cause_d = BUS_WB;
    else if (pf_bus_i)         bus_cause_d = BUS_PF;
    else                       bus_cause_d = BUS_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      order_q     <= '0;
      bus_req_q   <= 1'b0;
      bus_cause_q <= BUS_NONE;
    end else begin
      order_q     <= order_q + ORD_W'(mq_ok) + ORD_W'(wb_ok);
      bus_req_q   <= (bus_cause_d != BUS_NONE);
      bus_cause_q <= bus_cause_d;
    end
  end

  assign bus_req_o   = bus_req_q;
  assign bus_cause_o = bus_cause_q;
endmodule

// File: rtl/cblk_chk.sv
module cblk_chk #(
  parameter int CNT_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2:0]         blocked_i,
  input logic               accept_i,
  input logic               retry_i,
  input logic [3*CNT_W-1:0] evt_i,
  input logic [3*CNT_W-1:0] cyc_i,
  input logic               bus_req_i,
  input logic [1:0]         bus_cause_i
);
  p_mask_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocked_i != 3'b0) |-> !accept_i);

  p_evt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocked_i != 3'b0) |=> $stable(evt_i));

  p_cyc_on_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cyc_i) |-> $rose(accept_i));

  p_retry_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_i |=> !retry_i);

  p_retry_on_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_i |-> $rose(accept_i));

  p_bus_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i |-> (bus_cause_i != 2'd3));

  p_bus_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_i |-> (bus_cause_i == 2'd3));
endmodule

bind cache_block_ctrl cblk_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .blocked_i  (blocked_o),
  .accept_i   (cpu_accept_o),
  .retry_i    (cpu_retry_o),
  .evt_i      (evt_cnt_o),
  .cyc_i      (blk_cyc_o),
  .bus_req_i  (bus_req_o),
  .bus_cause_i(bus_cause_o)
);

// File: tb/cache_block_ctrl_test.sv
module cache_block_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int MQD = 4, WBD = 2, AW = 16, BLK = 16, OW = 8, CW = 8, CYW = 16;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mq_alloc = 0, mq_bus = 0, mq_mark = 0, wb_alloc = 0, wb_bus = 0, wb_mark = 0;
  logic pf_bus = 0, tgt_set = 0, tgt_clr = 0, cpu_req = 0;
  logic [AW-1:0] mq_addr = '0, wb_addr = '0;
  logic cpu_accept, cpu_retry, bus_req;
  logic [2:0] blocked;
  logic [AW-1:0] mq_blk, wb_blk;
  logic [OW-1:0] mq_ord, wb_ord;
  logic [1:0] alloc_err, bus_cause;
  logic [3*CW-1:0] evt_cnt, blk_cyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_block_ctrl #(.MQ_DEPTH(MQD), .WB_DEPTH(WBD), .ADDR_W(AW), .BLK_BYTES(BLK),
                     .ORD_W(OW), .CNT_W(CW), .CYC_W(CYW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .mq_alloc_i(mq_alloc), .mq_addr_i(mq_addr), .mq_bus_i(mq_bus), .mq_mark_i(mq_mark),
    .wb_alloc_i(wb_alloc), .wb_addr_i(wb_addr), .wb_bus_i(wb_bus), .wb_mark_i(wb_mark),
    .pf_bus_i(pf_bus), .tgt_set_i(tgt_set), .tgt_clr_i(tgt_clr), .cpu_req_i(cpu_req),
    .cpu_accept_o(cpu_accept), .cpu_retry_o(cpu_retry), .blocked_o(blocked),
    .mq_blk_addr_o(mq_blk), .wb_blk_addr_o(wb_blk), .mq_order_o(mq_ord), .wb_order_o(wb_ord),
    .alloc_err_o(alloc_err), .bus_req_o(bus_req), .bus_cause_o(bus_cause),
    .evt_cnt_o(evt_cnt), .blk_cyc_o(blk_cyc)
  );

  int n_chk = 0, n_fail = 0;
  int occm = 0, occw = 0, ord = 0, cyc = 0, start = 0;
  int evt[3] = '{0, 0, 0};
  int bcy[3] = '{0, 0, 0};
  bit [2:0] mask = 0;
  bit pend = 0, e_retry = 0, e_acc = 1, e_bus = 0;
  int e_cause = 3;
  string sect = "";
  bit [31:0] lfsr = 32'h1ace_b00c;

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", (sect != "") ? sect : tag, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  // one cycle: combinational checks, edge, model update, registered checks
  task automatic step();
    bit m_ok, w_ok, dm, dw;
    int occm_n, occw_n, el;
    bit [2:0] setv, clrv, mask_n;
    #1;
    m_ok = mq_alloc && occm < MQD;
    w_ok = wb_alloc && occw < WBD;
    chk("R9", "mq_err", alloc_err[0], mq_alloc && !m_ok);
    chk("R9", "wb_err", alloc_err[1], wb_alloc && !w_ok);
    if (m_ok) begin
      chk("R6", "mq_addr", mq_blk, mq_addr & ~(BLK - 1));
      chk("R6", "mq_order", mq_ord, ord % 256);
    end
    if (w_ok) begin
      chk("R6", "wb_addr", wb_blk, wb_addr & ~(BLK - 1));
      chk("R6", "wb_order", wb_ord, (ord + m_ok) % 256);
    end
    @(posedge clk);
    dm = mq_mark && occm > 0;
    dw = wb_mark && occw > 0;
    occm_n = occm + m_ok - dm;
    occw_n = occw + w_ok - dw;
    setv = {tgt_set, w_ok && occw_n == WBD, m_ok && occm_n == MQD};
    clrv = {tgt_clr, dw && occw == WBD && occw_n != WBD, dm && occm == MQD && occm_n != MQD};
    mask_n = (mask | setv) & ~clrv;
    e_retry = 0;
    if (mask == 0 && mask_n != 0) begin
      for (int i = 0; i < 3; i++) if (mask_n[i] && evt[i] < CMAX) evt[i]++;
      start = cyc;
    end
    if (mask != 0 && mask_n == 0) begin
      el = (cyc - start) & 16'hffff;
      for (int i = 0; i < 3; i++)
        if (clrv[i] && mask[i]) bcy[i] = (bcy[i] + el > CMAX) ? CMAX : bcy[i] + el;
      e_retry = pend || cpu_req;
      pend = 0;
    end else if (mask != 0 && cpu_req) pend = 1;
    if (m_ok && mq_bus) e_cause = 0;
    else if (w_ok && wb_bus) e_cause = 1;
    else if (pf_bus) e_cause = 2;
    else e_cause = 3;
    e_bus = (e_cause != 3);
    mask = mask_n;
    e_acc = (mask_n == 0);
    occm = occm_n; occw = occw_n;
    ord = (ord + m_ok + w_ok) % 256;
    cyc = (cyc + 1) & 16'hffff;
    @(negedge clk);
    chk("R7", "mask", blocked, mask);
    chk("R2", "accept", cpu_accept, e_acc);
    chk("R5", "retry", cpu_retry, e_retry);
    chk("R10", "bus_req", bus_req, e_bus);
    chk("R10", "bus_cause", bus_cause, e_cause);
    for (int i = 0; i < 3; i++) begin
      chk("R3", "evt", evt_cnt[i*CW +: CW], evt[i]);
      chk("R4", "blk_cyc", blk_cyc[i*CW +: CW], bcy[i]);
    end
  endtask

  task automatic idle_inputs();
    mq_alloc = 0; mq_bus = 0; mq_mark = 0; wb_alloc = 0; wb_bus = 0; wb_mark = 0;
    pf_bus = 0; tgt_set = 0; tgt_clr = 0; cpu_req = 0;
  endtask

  function automatic bit [31:0] nxt(input bit [31:0] s);
    bit [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1: reset state
    sect = "R1";
    chk("R1", "accept", cpu_accept, 1);
    chk("R1", "retry", cpu_retry, 0);
    chk("R1", "mask", blocked, 0);
    chk("R1", "bus_req", bus_req, 0);
    chk("R1", "evt", evt_cnt, 0);
    chk("R1", "blk_cyc", blk_cyc, 0);
    chk("R1", "order", mq_ord, 0);
    @(negedge clk);
    sect = "";
    cyc = 1;  // one edge elapsed above with idle inputs

    // R6/R7: fill the miss queue with bus requests
    for (int k = 0; k < MQD; k++) begin
      idle_inputs(); mq_alloc = 1; mq_bus = 1; mq_addr = 16'h1234 + 16'(k * 37);
      step();
    end
    // R9: allocation into a full queue is refused and consumes nothing
    sect = "R9";
    idle_inputs(); mq_alloc = 1; mq_addr = 16'hffff; cpu_req = 1; step();
    idle_inputs(); step();
    // R8: mark frees the queue and reopens the port, retry follows the refused request
    sect = "R8";
    idle_inputs(); mq_mark = 1; step();
    idle_inputs(); mq_mark = 1; step();
    idle_inputs(); step();
    // R11: same-cycle set and clear from an open port
    sect = "R11";
    idle_inputs(); tgt_set = 1; tgt_clr = 1; step();
    idle_inputs(); step();
    // R5: stall without a refused request gives no retry
    sect = "R5";
    idle_inputs(); tgt_set = 1; step();
    idle_inputs(); step();
    idle_inputs(); tgt_clr = 1; step();
    idle_inputs(); tgt_set = 1; step();
    idle_inputs(); tgt_clr = 1; cpu_req = 1; step();
    // R12: saturate the episode counter and the stalled-cycle counter
    sect = "R12";
    for (int k = 0; k < 270; k++) begin
      idle_inputs(); tgt_set = 1; step();
      idle_inputs(); tgt_clr = 1; step();
    end
    idle_inputs(); wb_alloc = 1; wb_bus = 1; wb_addr = 16'h00ab; step();
    idle_inputs(); wb_alloc = 1; wb_addr = 16'h7777; pf_bus = 1; step();
    for (int k = 0; k < 300; k++) begin idle_inputs(); step(); end
    idle_inputs(); wb_mark = 1; step();
    idle_inputs(); wb_mark = 1; step();
    sect = "";

    // pseudo-random sweep with biased rates
    for (int k = 0; k < 8000; k++) begin
      lfsr = nxt(lfsr);
      mq_alloc = lfsr[2:0] < 3;
      wb_alloc = lfsr[5:3] < 2;
      mq_mark  = lfsr[8:6] < 2;
      wb_mark  = lfsr[11:9] == 0;
      mq_bus   = lfsr[12];
      wb_bus   = lfsr[13];
      pf_bus   = lfsr[15:14] == 0;
      tgt_set  = lfsr[19:16] == 0;
      tgt_clr  = lfsr[23:20] < 2;
      cpu_req  = lfsr[24];
      lfsr = nxt(lfsr);
      mq_addr = lfsr[15:0];
      wb_addr = lfsr[31:16];
      step();
    end
    idle_inputs();
    finish_run();
  end
endmodule